// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns a 24-bit bus address and a few bus-cycle qualifiers into four active-low select lines for external devices. Each of the four channels has three 8-bit registers: control, lower bound and upper bound. A channel decodes either memory space or I/O space, never both. In memory space it claims a range of 64 KB pages, and both ends of the range are inclusive. In I/O space it claims one 256-byte section, and the lower-bound register holds that section's base.

When several channels claim the same access, the lowest-numbered enabled channel wins. The winning channel may stretch the access with up to seven wait states. A memory access that hits a channel also drives the memory-request strobe. The read or write strobe follows the direction of the access whenever any select is active. The registers are loaded through a plain synchronous write port. The decode is combinational from the address, the qualifiers and the current register contents.

Top module: `chip_sel_dec`

## Requirements
- R1: After reset, all four selects, the memory-request, read and write strobes and the wait output are high. Every channel is disabled, set to memory space and set to zero wait states.
- R2: A write with regWrEn high loads regWrData into channel regChan at the next rising edge. regField selects the register: 0 for control, 1 for lower bound, 2 for upper bound. The decode uses the new value from that edge onward, including in the middle of an access.
- R3: A channel asserts its select only while its control bit 3 (the enable) is 1.
- R4: Control bit 4 sets the space: 0 means memory and 1 means I/O. A memory channel never asserts during an I/O cycle, and an I/O channel never asserts during a memory cycle.
- R5: A memory channel hits when its lower bound is at most addr[23:16] and addr[23:16] is at most its upper bound. Both ends count as hits. Equal bounds cover exactly one 64 KB page.
- R6: An I/O channel hits when addr[15:8] equals its lower-bound register. An I/O hit never drives memRqN low.
- R7: When several channels hit, only the lowest-numbered one drives its csN bit low.
- R8: memRqN is low exactly during a memory cycle that has a hit. Whenever a select is low, rdN is low for a read (cycIsWrite = 0) and wrN is low for a write. Both are high when no channel hits.
- R9: Control bits [7:5] hold the wait count N of the winning channel. waitN is low during the first N clocks of an access, counted from the rise of cycValid. It is high from clock N onward. cycValid must fall between accesses.
- R10: A write with regField = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regChan | input | 2 | Channel addressed by the write |
| regField | input | 2 | Register addressed: 0 control, 1 lower, 2 upper, 3 none |
| regWrData | input | 8 | Write data |
| cycValid | input | 1 | A bus access is in progress |
| cycIsIo | input | 1 | Access targets I/O space (0 = memory) |
| cycIsWrite | input | 1 | Access direction (1 = write) |
| addr | input | 24 | Bus address |
| csN | output | 4 | Active-low selects, bit i for channel i |
| memRqN | output | 1 | Active-low memory request |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| waitN | output | 1 | Active-low wait request |

## Verification
A register write and a running decode can land in the same clock. For example, the winning channel can be disabled while its access is still held. The bench starts an access that hits both channel 0 and the catch-all channel 3. With cycValid still high, it writes 0 into the control register of channel 0. It checks that channel 0's select is low just before the write edge and that channel 3 has taken over just after it. The wait counter shares cycles with decode changes in the same way, and the wait test checks waitN on every clock of a held access.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int EN_BIT = 3;
  localparam int IO_BIT = 4;
  localparam int WS_LSB = 5;

  typedef struct packed {
    logic wrCtrl;
    logic wrLow;
    logic wrUp;
    logic memAct;
    logic ioAct;
  } csd_strobe_t;
endpackage

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int WS_W   = 3,
  parameter int IO_LSB = 8,
  localparam int CH_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  csd_strobe_t       stb,
  input  logic [CH_W-1:0]   regChan,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CS-1:0] csN,
  output logic              hitAny,
  output logic [WS_W-1:0]   winWs
);
  logic [DATA_W-1:0] ctrlQ [NUM_CS];
  logic [DATA_W-1:0] lowQ  [NUM_CS];
  logic [DATA_W-1:0] upQ   [NUM_CS];
  logic [NUM_CS-1:0] match;
  logic [NUM_CS-1:0] win;
  logic [DATA_W-1:0] page;
  logic [DATA_W-1:0] ioSec;

  assign page  = addr[ADDR_W-1 -: DATA_W];
  assign ioSec = addr[IO_LSB +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CS; i++) begin
        ctrlQ[i] <= '0;
        lowQ[i]  <= '0;
        upQ[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (regChan == CH_W'(i)) begin
          if (stb.wrCtrl) ctrlQ[i] <= regWrData;
          if (stb.wrLow)  lowQ[i]  <= regWrData;
          if (stb.wrUp)   upQ[i]   <= regWrData;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gChan
    logic memMatch;
    logic ioMatch;
    assign memMatch = stb.memAct && (page >= lowQ[g]) && (page <= upQ[g]);
    assign ioMatch  = stb.ioAct && (ioSec == lowQ[g]);
    assign match[g] = ctrlQ[g][EN_BIT] && (ctrlQ[g][IO_BIT] ? ioMatch : memMatch);

    // R3
    cs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !csN[g] |-> ctrlQ[g][EN_BIT]);

    // R4
    cs_space_chk: assert property (@(posedge clk) disable iff (!rstN)
      !csN[g] |-> (ctrlQ[g][IO_BIT] ? stb.ioAct : stb.memAct));
  end

  always_comb begin
    win    = '0;
    winWs  = '0;
    hitAny = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (match[i] && !hitAny) begin
        win[i] = 1'b1;
        winWs  = ctrlQ[i][WS_LSB +: WS_W];
        hitAny = 1'b1;
      end
    end
  end

  assign csN = ~win;

  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
endmodule

// File: rtl/csd_control.sv
module csd_control
  import csd_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [1:0]      regField,
  input  logic            cycValid,
  input  logic            cycIsIo,
  input  logic            cycIsWrite,
  input  logic            hitAny,
  input  logic [WS_W-1:0] winWs,
  output csd_strobe_t     stb,
  output logic            memRqN,
  output logic            rdN,
  output logic            wrN,
  output logic            waitN
);
  logic [WS_W-1:0] waitCnt;

  always_comb begin
    stb.wrCtrl = regWrEn && (regField == 2'd0);
    stb.wrLow  = regWrEn && (regField == 2'd1);
    stb.wrUp   = regWrEn && (regField == 2'd2);
    stb.memAct = cycValid && !cycIsIo;
    stb.ioAct  = cycValid && cycIsIo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (!cycValid)        waitCnt <= '0;
    else if (waitCnt != '1)    waitCnt <= waitCnt + 1'b1;
  end

  assign memRqN = !(stb.memAct && hitAny);
  assign rdN    = !(hitAny && !cycIsWrite);
  assign wrN    = !(hitAny && cycIsWrite);
  assign waitN  = !(cycValid && hitAny && (waitCnt < winWs));

  // R6
  memrq_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRqN |-> !cycIsIo);

  // R8
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R9
  wait_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> (cycValid && hitAny));

  // R9
  wait_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && $past(cycValid) && $past(waitN) && $past(hitAny) && hitAny
     && $stable(winWs)) |-> waitN);
endmodule

// File: rtl/chip_sel_dec.sv
module chip_sel_dec
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int WS_W   = 3,
  localparam int CH_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CH_W-1:0]   regChan,
  input  logic [1:0]        regField,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cycValid,
  input  logic              cycIsIo,
  input  logic              cycIsWrite,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CS-1:0] csN,
  output logic              memRqN,
  output logic              rdN,
  output logic              wrN,
  output logic              waitN
);
  csd_strobe_t     stb;
  logic            hitAny;
  logic [WS_W-1:0] winWs;

  csd_control #(.WS_W(WS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regField(regField),
    .cycValid(cycValid), .cycIsIo(cycIsIo), .cycIsWrite(cycIsWrite),
    .hitAny(hitAny), .winWs(winWs), .stb(stb),
    .memRqN(memRqN), .rdN(rdN), .wrN(wrN), .waitN(waitN)
  );

  csd_datapath #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regChan(regChan), .regWrData(regWrData),
    .addr(addr), .csN(csN), .hitAny(hitAny), .winWs(winWs)
  );
endmodule

// File: tb/chip_sel_dec_tb_top.sv
`timescale 1ns/1ps
module chip_sel_dec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regChan = '0;
  logic [1:0]  regField = '0;
  logic [7:0]  regWrData = '0;
  logic        cycValid = 1'b0;
  logic        cycIsIo = 1'b0;
  logic        cycIsWrite = 1'b0;
  logic [23:0] addr = '0;
  logic [3:0]  csN;
  logic        memRqN, rdN, wrN, waitN;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  chip_sel_dec dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regChan(regChan), .regField(regField),
    .regWrData(regWrData), .cycValid(cycValid), .cycIsIo(cycIsIo), .cycIsWrite(cycIsWrite),
    .addr(addr), .csN(csN), .memRqN(memRqN), .rdN(rdN), .wrN(wrN), .waitN(waitN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] ch, input logic [1:0] fld, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regChan = ch; regField = fld; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic startCyc(input logic [23:0] a, input logic io, input logic wr);
    @(negedge clk);
    addr = a; cycIsIo = io; cycIsWrite = wr; cycValid = 1'b1;
    #1;
  endtask

  task automatic endCyc();
    @(negedge clk);
    cycValid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 csN", csN, 4'hF);
    check("R1 strobes", {memRqN, rdN, wrN, waitN}, 4'hF);
    startCyc(24'h000000, 1'b0, 1'b0);
    check("R1 all disabled", csN, 4'hF);
    check("R8 no hit memRqN/rdN", {memRqN, rdN}, 2'b11);
    endCyc();
  endtask

  task automatic t_enable();
    writeReg(2'd0, 2'd1, 8'h10);
    writeReg(2'd0, 2'd2, 8'h20);
    startCyc(24'h150000, 1'b0, 1'b0);
    check("R3 disabled channel silent", csN, 4'hF);
    endCyc();
    writeReg(2'd0, 2'd0, 8'h08);
    startCyc(24'h150000, 1'b0, 1'b0);
    check("R3 enabled channel asserts", csN, 4'hE);
    endCyc();
  endtask

  task automatic t_range();
    startCyc(24'h10ABCD, 1'b0, 1'b0); check("R5 lower edge", csN, 4'hE); endCyc();
    startCyc(24'h20FFFF, 1'b0, 1'b0); check("R5 upper edge", csN, 4'hE); endCyc();
    startCyc(24'h0FFFFF, 1'b0, 1'b0); check("R5 below", csN, 4'hF); endCyc();
    startCyc(24'h210000, 1'b0, 1'b0); check("R5 above", csN, 4'hF); endCyc();
    writeReg(2'd1, 2'd1, 8'h40);
    writeReg(2'd1, 2'd2, 8'h40);
    writeReg(2'd1, 2'd0, 8'h08);
    startCyc(24'h401234, 1'b0, 1'b0); check("R5 single page hit", csN, 4'hD); endCyc();
    startCyc(24'h411234, 1'b0, 1'b0); check("R5 single page next", csN, 4'hF); endCyc();
  endtask

  task automatic t_io();
    writeReg(2'd2, 2'd1, 8'h3A);
    writeReg(2'd2, 2'd0, 8'h18);
    startCyc(24'h003A55, 1'b1, 1'b0);
    check("R6 io hit", csN, 4'hB);
    check("R6 io no memRqN", memRqN, 1'b1);
    check("R8 io read strobe", {rdN, wrN}, 2'b01);
    endCyc();
    startCyc(24'h003B00, 1'b1, 1'b0); check("R6 io miss", csN, 4'hF); endCyc();
    startCyc(24'h3A3A00, 1'b0, 1'b0); check("R4 io channel ignores memory", csN, 4'hF); endCyc();
    startCyc(24'h153A00, 1'b1, 1'b0); check("R4 memory channel ignores io", csN, 4'hB); endCyc();
  endtask

  task automatic t_prio();
    writeReg(2'd3, 2'd1, 8'h00);
    writeReg(2'd3, 2'd2, 8'hFF);
    writeReg(2'd3, 2'd0, 8'h08);
    startCyc(24'h150000, 1'b0, 1'b0); check("R7 lowest wins", csN, 4'hE); endCyc();
    startCyc(24'h400000, 1'b0, 1'b0); check("R7 ch1 over ch3", csN, 4'hD); endCyc();
    startCyc(24'h300000, 1'b0, 1'b0); check("R7 ch3 alone", csN, 4'h7); endCyc();
  endtask

  task automatic t_strobes();
    startCyc(24'h150000, 1'b0, 1'b1);
    check("R8 mem write strobes", {memRqN, rdN, wrN}, 3'b010);
    endCyc();
    startCyc(24'h150000, 1'b0, 1'b0);
    check("R8 mem read strobes", {memRqN, rdN, wrN}, 3'b001);
    endCyc();
    check("R8 idle strobes", {memRqN, rdN, wrN}, 3'b111);
  endtask

  task automatic t_wait();
    writeReg(2'd0, 2'd0, 8'h68);
    startCyc(24'h150000, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      check($sformatf("R9 ws3 clock %0d", k), waitN, (k < 3) ? 1'b0 : 1'b1);
      @(negedge clk); #1;
    end
    endCyc();
    check("R9 idle waitN", waitN, 1'b1);
    startCyc(24'h300000, 1'b0, 1'b0);
    check("R9 zero wait", waitN, 1'b1);
    endCyc();
  endtask

  task automatic t_field3();
    writeReg(2'd0, 2'd3, 8'h00);
    startCyc(24'h150000, 1'b0, 1'b0);
    check("R10 field 3 ignored", csN, 4'hE);
    check("R10 ws kept", waitN, 1'b0);
    endCyc();
  endtask

  task automatic t_race();
    startCyc(24'h150000, 1'b0, 1'b0);
    check("R2 before mid-access write", csN, 4'hE);
    writeReg(2'd0, 2'd0, 8'h00);
    #1;
    check("R2 after mid-access write", csN, 4'h7);
    endCyc();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_enable();
    t_range();
    t_io();
    t_prio();
    t_strobes();
    t_wait();
    t_field3();
    t_race();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule